// File: doc/BRIEF.md
# Virtual-8086 Return Frame Loader

This block finishes an interrupt return that drops back into virtual-8086 mode from privilege level 0 with a 32-bit operand size. The earlier stage has already popped the instruction pointer, the code selector and the flags image, and hands them over together with a start pulse. The loader then owns the rest of the stack frame. That frame has nine 4-byte slots in all, and the first three are the ones already consumed.

On start the loader first confirms that the whole 36-byte frame fits inside the stack segment limit. If it does not, the loader raises a stack-fault strobe with error code zero and changes nothing. If the frame fits, the loader fetches the six remaining slots through a one-request-at-a-time memory read port. These slots hold the new stack pointer, the stack selector and the four data selectors. The loader then commits all of the new register values in one edge, and pulses done in the next cycle. For every segment it also presents a real-mode-style descriptor cache, with a base of the selector times sixteen, a 64 KiB limit and fixed attributes.

Top module: `v86_frame_loader`

## Requirements
- R1: After reset, done_o, fault_o and rd_req_o are low, new_eip_o, new_esp_o and new_flags_o are zero, every selector is zero, and every attribute field is zero, including its valid bit 0.
- R2: At start the working stack pointer plus 35 must not exceed ss_limit_i, compared without wrap. Otherwise fault_o pulses for exactly one cycle, two cycles after the start edge. In that case no read is requested and no output register changes.
- R3: The working stack pointer is all of cur_esp_i when ss_big_i is 1, and only its low 16 bits, zero-extended, when ss_big_i is 0.
- R4: The reads go out in a fixed order at byte offsets 12, 16, 20, 24, 28 and 32. Each read address is the stack base plus the working stack pointer plus the offset, taken modulo 2^32. Only one read is outstanding at a time, and rd_addr_o holds while rd_req_o is high and rd_ready_i is low.
- R5: The word read at offset 12 becomes new_esp_o with all 32 bits. The selectors at offsets 16, 20, 24, 28 and 32 (SS, ES, DS, FS, GS) take the low 16 bits of their words.
- R6: new_eip_o takes bits 15:0 of ret_eip_i, and its upper 16 bits are zero. The CS selector takes ret_cs_i, and new_flags_o takes ret_flags_i unchanged.
- R7: The packed segment outputs use index 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS. For each segment, base equals the selector shifted left by 4, and limit equals 0x0000FFFF.
- R8: Each 12-bit attribute field has these bits once loaded: bit0 valid, bit1 present, bit2 accessed and bit3 writable are all 1. Bit4 executable is 1 only for CS. Bit5 expand-down/conforming, bit6 granularity and bit7 default-size are 0. Bits 9:8 DPL and bits 11:10 RPL are both 3. This gives 0xF1F for CS and 0xF0F for the others.
- R9: done_o is a one-cycle pulse in the cycle after the edge that loads the outputs. It is never high together with fault_o.
- R10: A start pulse that arrives while a frame is being loaded is ignored. The committed values all come from the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin loading a frame (sampled in idle only) |
| ret_eip_i | input | 32 | Instruction pointer image already popped |
| ret_cs_i | input | 16 | Code selector already popped |
| ret_flags_i | input | 32 | Flags image already popped |
| cur_esp_i | input | 32 | Current stack pointer register |
| ss_big_i | input | 1 | Stack segment default-size bit |
| ss_base_i | input | 32 | Stack segment base |
| ss_limit_i | input | 32 | Stack segment limit (byte) |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Linear read address |
| rd_ready_i | input | 1 | Read accepted, data valid this cycle |
| rd_data_i | input | 32 | Read data |
| new_eip_o | output | 32 | Loaded instruction pointer |
| new_esp_o | output | 32 | Loaded stack pointer |
| new_flags_o | output | 32 | Loaded flags image |
| seg_sel_o | output | 96 | Six 16-bit selectors, packed by segment index |
| seg_base_o | output | 192 | Six 32-bit cache bases |
| seg_limit_o | output | 192 | Six 32-bit cache limits |
| seg_attr_o | output | 72 | Six 12-bit attribute fields |
| done_o | output | 1 | Frame committed |
| fault_o | output | 1 | Stack fault, error code zero |

## Verification
The hardest case to reach from the ports is a read request that stalls for several cycles while a second start pulse lands in the middle of the load. The same run must still commit only the first request's values. The bench throttles rd_ready_i at random and fires a decoy start with unrelated inputs during busy runs. Limit boundaries are hit directly with stack pointers at exactly limit-35 and limit-34. The 16-bit stack mode is run with junk in the upper pointer bits.

// File: rtl/v86_pkg.sv
package v86_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_COMMIT = 3'd2,
    ST_DONE   = 3'd3,
    ST_FAULT  = 3'd4
  } ld_state_e;

  // segment index order inside the packed outputs
  localparam int SEG_ES = 0;
  localparam int SEG_CS = 1;
  localparam int SEG_SS = 2;
  localparam int SEG_DS = 3;
  localparam int SEG_FS = 4;
  localparam int SEG_GS = 5;

  // attribute field layout
  localparam int AT_VALID = 0;
  localparam int AT_PRES  = 1;
  localparam int AT_ACC   = 2;
  localparam int AT_WR    = 3;
  localparam int AT_EXEC  = 4;
  localparam int AT_EDC   = 5;
  localparam int AT_GRAN  = 6;
  localparam int AT_BIG   = 7;
  localparam int AT_DPL   = 8;
  localparam int AT_RPL   = 10;
  localparam int ATTR_W   = 12;

  // read slot k (0 = stack pointer) -> destination segment for k >= 1
  function automatic int slot_to_seg(input int k);
    case (k)
      1:       return SEG_SS;
      2:       return SEG_ES;
      3:       return SEG_DS;
      4:       return SEG_FS;
      default: return SEG_GS;
    endcase
  endfunction

endpackage

// File: rtl/v86_frame_check.sv
module v86_frame_check #(
  parameter int ADDR_W      = 32,
  parameter int FRAME_BYTES = 36
) (
  input  logic [ADDR_W-1:0] cur_esp_i,
  input  logic              ss_big_i,
  input  logic [ADDR_W-1:0] ss_limit_i,
  output logic [ADDR_W-1:0] esp_eff_o,
  output logic              frame_ok_o
);
  localparam int HALF_W = 16;

  logic [ADDR_W:0] last_byte;

  always_comb begin
    if (ss_big_i) esp_eff_o = cur_esp_i;
    else          esp_eff_o = {{(ADDR_W-HALF_W){1'b0}}, cur_esp_i[HALF_W-1:0]};
    last_byte  = {1'b0, esp_eff_o} + (ADDR_W+1)'(FRAME_BYTES - 1);
    frame_ok_o = (last_byte <= {1'b0, ss_limit_i});
  end

endmodule

// File: rtl/v86_slot_seq.sv
module v86_slot_seq
  import v86_pkg::*;
#(
  parameter int NREAD = 6,
  localparam int IDX_W = $clog2(NREAD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             frame_ok_i,
  input  logic             rd_ready_i,
  output logic             ctx_load_o,
  output logic             rd_req_o,
  output logic             cap_en_o,
  output logic [IDX_W-1:0] slot_o,
  output logic             commit_o,
  output logic             done_o,
  output logic             fault_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREAD - 1);

  ld_state_e        state_q, state_d;
  logic [IDX_W-1:0] slot_q, slot_d;
  logic             slot_en;

  always_comb begin
    state_d    = state_q;
    slot_d     = slot_q;
    slot_en    = 1'b0;
    ctx_load_o = 1'b0;
    rd_req_o   = 1'b0;
    cap_en_o   = 1'b0;
    commit_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctx_load_o = frame_ok_i;
          slot_en    = 1'b1;
          slot_d     = '0;
          state_d    = frame_ok_i ? ST_READ : ST_FAULT;
        end
      end
      ST_READ: begin
        rd_req_o = 1'b1;
        if (rd_ready_i) begin
          cap_en_o = 1'b1;
          slot_en  = 1'b1;
          if (slot_q == LAST) begin
            slot_d  = '0;
            state_d = ST_COMMIT;
          end else begin
            slot_d = slot_q + 1'b1;
          end
        end
      end
      ST_COMMIT: begin
        commit_o = 1'b1;
        state_d  = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (slot_en) begin
      slot_q <= slot_d;
    end
  end

  assign slot_o  = slot_q;
  assign done_o  = (state_q == ST_DONE);
  assign fault_o = (state_q == ST_FAULT);

endmodule

// File: rtl/v86_seg_cache.sv
module v86_seg_cache
  import v86_pkg::*;
#(
  parameter int   SEL_W   = 16,
  parameter int   ADDR_W  = 32,
  parameter logic IS_CODE = 1'b0
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              loaded_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] limit_o,
  output logic [ATTR_W-1:0] attr_o
);
  localparam int PARA_SH = 4;
  localparam logic [ADDR_W-1:0] REAL_LIMIT = ADDR_W'((64'd1 << SEL_W) - 64'd1);

  always_comb begin
    base_o  = ADDR_W'({sel_i, {PARA_SH{1'b0}}});
    limit_o = REAL_LIMIT;
    attr_o  = '0;
    if (loaded_i) begin
      attr_o[AT_VALID]         = 1'b1;
      attr_o[AT_PRES]          = 1'b1;
      attr_o[AT_ACC]           = 1'b1;
      attr_o[AT_WR]            = 1'b1;
      attr_o[AT_EXEC]          = IS_CODE;
      attr_o[AT_EDC]           = 1'b0;
      attr_o[AT_GRAN]          = 1'b0;
      attr_o[AT_BIG]           = 1'b0;
      attr_o[AT_DPL+1:AT_DPL]  = 2'd3;
      attr_o[AT_RPL+1:AT_RPL]  = 2'd3;
    end
  end

endmodule

// File: rtl/v86_frame_loader.sv
module v86_frame_loader
  import v86_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 16,
  parameter int NSEG        = 6,
  parameter int SLOT_BYTES  = 4,
  parameter int FRAME_SLOTS = 9,
  parameter int PRE_POPPED  = 3,
  parameter int IP_KEEP_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [DATA_W-1:0]        ret_eip_i,
  input  logic [SEL_W-1:0]         ret_cs_i,
  input  logic [DATA_W-1:0]        ret_flags_i,
  input  logic [ADDR_W-1:0]        cur_esp_i,
  input  logic                     ss_big_i,
  input  logic [ADDR_W-1:0]        ss_base_i,
  input  logic [ADDR_W-1:0]        ss_limit_i,
  output logic                     rd_req_o,
  output logic [ADDR_W-1:0]        rd_addr_o,
  input  logic                     rd_ready_i,
  input  logic [DATA_W-1:0]        rd_data_i,
  output logic [DATA_W-1:0]        new_eip_o,
  output logic [DATA_W-1:0]        new_esp_o,
  output logic [DATA_W-1:0]        new_flags_o,
  output logic [NSEG*SEL_W-1:0]    seg_sel_o,
  output logic [NSEG*ADDR_W-1:0]   seg_base_o,
  output logic [NSEG*ADDR_W-1:0]   seg_limit_o,
  output logic [NSEG*ATTR_W-1:0]   seg_attr_o,
  output logic                     done_o,
  output logic                     fault_o
);
  localparam int NREAD       = FRAME_SLOTS - PRE_POPPED;
  localparam int FRAME_BYTES = FRAME_SLOTS * SLOT_BYTES;
  localparam int IDX_W       = $clog2(NREAD);

  logic [ADDR_W-1:0] esp_eff;
  logic              frame_ok;
  logic              ctx_load, cap_en, commit;
  logic [IDX_W-1:0]  slot;

  // request context
  logic [IP_KEEP_W-1:0] ctx_ip_q;
  logic [SEL_W-1:0]     ctx_cs_q;
  logic [DATA_W-1:0]    ctx_flags_q;
  logic [ADDR_W-1:0]    ctx_base_q;
  logic [ADDR_W-1:0]    ctx_esp_q;

  // captured frame words
  logic [DATA_W-1:0] slot_q [NREAD];

  // committed state
  logic [DATA_W-1:0] eip_q, esp_q, flags_q;
  logic [SEL_W-1:0]  sel_q [NSEG];
  logic              loaded_q;

  logic unused_hi;
  assign unused_hi = ^{ret_eip_i[DATA_W-1:IP_KEEP_W]};

  v86_frame_check #(
    .ADDR_W      (ADDR_W),
    .FRAME_BYTES (FRAME_BYTES)
  ) u_check (
    .cur_esp_i  (cur_esp_i),
    .ss_big_i   (ss_big_i),
    .ss_limit_i (ss_limit_i),
    .esp_eff_o  (esp_eff),
    .frame_ok_o (frame_ok)
  );

  v86_slot_seq #(
    .NREAD (NREAD)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .frame_ok_i (frame_ok),
    .rd_ready_i (rd_ready_i),
    .ctx_load_o (ctx_load),
    .rd_req_o   (rd_req_o),
    .cap_en_o   (cap_en),
    .slot_o     (slot),
    .commit_o   (commit),
    .done_o     (done_o),
    .fault_o    (fault_o)
  );

  // linear address of the current slot
  always_comb begin
    rd_addr_o = ctx_base_q + ctx_esp_q
              + ADDR_W'((32'(PRE_POPPED) + 32'(slot)) * 32'(SLOT_BYTES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_ip_q    <= '0;
      ctx_cs_q    <= '0;
      ctx_flags_q <= '0;
      ctx_base_q  <= '0;
      ctx_esp_q   <= '0;
    end else if (ctx_load) begin
      ctx_ip_q    <= ret_eip_i[IP_KEEP_W-1:0];
      ctx_cs_q    <= ret_cs_i;
      ctx_flags_q <= ret_flags_i;
      ctx_base_q  <= ss_base_i;
      ctx_esp_q   <= esp_eff;
    end
  end

  for (genvar k = 0; k < NREAD; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[k] <= '0;
      end else if (cap_en && (slot == IDX_W'(k))) begin
        slot_q[k] <= rd_data_i;
      end
    end
  end

  logic unused_slot_hi;
  always_comb begin
    unused_slot_hi = 1'b0;
    for (int k = 1; k < NREAD; k++) begin
      unused_slot_hi = unused_slot_hi ^ (^slot_q[k][DATA_W-1:SEL_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eip_q    <= '0;
      esp_q    <= '0;
      flags_q  <= '0;
      loaded_q <= 1'b0;
    end else if (commit) begin
      eip_q    <= DATA_W'(ctx_ip_q);
      esp_q    <= slot_q[0];
      flags_q  <= ctx_flags_q;
      loaded_q <= 1'b1;
    end
  end

  // selector registers: CS from context, others from frame slots
  for (genvar s = 0; s < NSEG; s++) begin : g_sel
    logic [SEL_W-1:0] sel_d;
    always_comb begin
      sel_d = sel_q[s];
      if (s == SEG_CS) begin
        sel_d = ctx_cs_q;
      end else begin
        for (int k = 1; k < NREAD; k++) begin
          if (slot_to_seg(k) == s) sel_d = slot_q[k][SEL_W-1:0];
        end
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[s] <= '0;
      end else if (commit) begin
        sel_q[s] <= sel_d;
      end
    end

    v86_seg_cache #(
      .SEL_W   (SEL_W),
      .ADDR_W  (ADDR_W),
      .IS_CODE (s == SEG_CS)
    ) u_cache (
      .sel_i    (sel_q[s]),
      .loaded_i (loaded_q),
      .base_o   (seg_base_o[s*ADDR_W +: ADDR_W]),
      .limit_o  (seg_limit_o[s*ADDR_W +: ADDR_W]),
      .attr_o   (seg_attr_o[s*ATTR_W +: ATTR_W])
    );

    assign seg_sel_o[s*SEL_W +: SEL_W] = sel_q[s];
  end

  assign new_eip_o   = eip_q;
  assign new_esp_o   = esp_q;
  assign new_flags_o = flags_q;

endmodule

// File: rtl/v86_frame_loader_chk.sv
module v86_frame_loader_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16,
  parameter int NSEG   = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  done_o,
  input logic                  fault_o,
  input logic                  rd_req_o,
  input logic                  rd_ready_i,
  input logic [ADDR_W-1:0]     rd_addr_o,
  input logic [DATA_W-1:0]     new_eip_o,
  input logic [DATA_W-1:0]     new_esp_o,
  input logic [NSEG*SEL_W-1:0] seg_sel_o
);

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_fault_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> ($stable(new_esp_o) && $stable(seg_sel_o) && !rd_req_o));

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)));

  assert_eip_trunc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (new_eip_o[DATA_W-1:16] == '0));

endmodule

bind v86_frame_loader v86_frame_loader_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W),
  .NSEG   (NSEG)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .rd_req_o   (rd_req_o),
  .rd_ready_i (rd_ready_i),
  .rd_addr_o  (rd_addr_o),
  .new_eip_o  (new_eip_o),
  .new_esp_o  (new_esp_o),
  .seg_sel_o  (seg_sel_o)
);

// File: tb/v86_frame_loader_tb.sv
`timescale 1ns/1ps
module v86_frame_loader_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] ret_eip_i, ret_flags_i, cur_esp_i, ss_base_i, ss_limit_i;
  logic [15:0] ret_cs_i;
  logic        ss_big_i;
  logic        rd_req_o, rd_ready_i;
  logic [31:0] rd_addr_o, rd_data_i;
  logic [31:0] new_eip_o, new_esp_o, new_flags_o;
  logic [95:0] seg_sel_o;
  logic [191:0] seg_base_o, seg_limit_o;
  logic [71:0] seg_attr_o;
  logic        done_o, fault_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  v86_frame_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ret_eip_i(ret_eip_i), .ret_cs_i(ret_cs_i), .ret_flags_i(ret_flags_i),
    .cur_esp_i(cur_esp_i), .ss_big_i(ss_big_i), .ss_base_i(ss_base_i),
    .ss_limit_i(ss_limit_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ready_i(rd_ready_i), .rd_data_i(rd_data_i),
    .new_eip_o(new_eip_o), .new_esp_o(new_esp_o), .new_flags_o(new_flags_o),
    .seg_sel_o(seg_sel_o), .seg_base_o(seg_base_o), .seg_limit_o(seg_limit_o),
    .seg_attr_o(seg_attr_o), .done_o(done_o), .fault_o(fault_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      finish_run();
    end
  end

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234 ^ {a[15:0], a[31:16]};
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // snapshot for fault / ignore checks
  logic [31:0] p_eip, p_esp, p_flags;
  logic [95:0] p_sel;

  task automatic run_case(input logic [31:0] eip, input logic [15:0] cs,
                          input logic [31:0] flags, input logic [31:0] base,
                          input logic [31:0] lim, input logic big,
                          input logic [31:0] esp, input bit poke, input int ready_pct);
    logic [31:0] eff, exp_addr [6], exp_word [6];
    logic [32:0] last;
    bit ok, seen;
    int idx;
    eff  = big ? esp : {16'h0, esp[15:0]};
    last = {1'b0, eff} + 33'd35;
    ok   = (last <= {1'b0, lim});
    for (int k = 0; k < 6; k++) begin
      exp_addr[k] = base + eff + 32'(12 + 4 * k);
      exp_word[k] = mem_word(exp_addr[k]);
    end
    p_eip = new_eip_o; p_esp = new_esp_o; p_flags = new_flags_o; p_sel = seg_sel_o;

    @(negedge clk);
    start_i = 1'b1; ret_eip_i = eip; ret_cs_i = cs; ret_flags_i = flags;
    ss_base_i = base; ss_limit_i = lim; ss_big_i = big; cur_esp_i = esp;
    @(negedge clk);
    start_i = 1'b0;
    idx = 0; seen = 0;
    for (int c = 0; c < 400 && !seen; c++) begin
      // decoy start while busy (R10)
      if (poke && c == 2) begin
        start_i = 1'b1; ret_eip_i = ~eip; ret_cs_i = ~cs; ret_flags_i = ~flags;
        ss_base_i = base + 32'h100; cur_esp_i = esp + 32'h40; ss_limit_i = 32'hFFFF_FFFF;
      end else begin
        start_i = 1'b0;
      end
      if (done_o || fault_o) begin
        seen = 1;
        if (done_o && fault_o) chk("R9 exclusive", 1, 0);
        if (!ok) begin
          chk("R2 fault raised", {fault_o, done_o}, 2'b10);
          chk("R2 no reads", idx, 0);
          chk("R2 esp unchanged", new_esp_o, p_esp);
          chk("R2 eip unchanged", new_eip_o, p_eip);
          chk("R2 selectors unchanged", seg_sel_o, p_sel);
        end else begin
          chk("R9 done raised", {fault_o, done_o}, 2'b01);
          chk("R4 read count", idx, 6);
          chk("R6 eip truncated", new_eip_o, {16'h0, eip[15:0]});
          chk("R6 flags", new_flags_o, flags);
          chk("R5 esp full width", new_esp_o, exp_word[0]);
          chk("R6 cs selector", seg_sel_o[16 +: 16], cs);
          chk("R5 ss selector", seg_sel_o[32 +: 16], exp_word[1][15:0]);
          chk("R5 es selector", seg_sel_o[0 +: 16], exp_word[2][15:0]);
          chk("R5 ds selector", seg_sel_o[48 +: 16], exp_word[3][15:0]);
          chk("R5 fs selector", seg_sel_o[64 +: 16], exp_word[4][15:0]);
          chk("R5 gs selector", seg_sel_o[80 +: 16], exp_word[5][15:0]);
          for (int s = 0; s < 6; s++) begin
            chk("R7 base", seg_base_o[s*32 +: 32], {12'h0, seg_sel_o[s*16 +: 16], 4'h0});
            chk("R7 limit", seg_limit_o[s*32 +: 32], 32'h0000_FFFF);
            chk("R8 attr", seg_attr_o[s*12 +: 12], (s == 1) ? 12'hF1F : 12'hF0F);
          end
        end
      end else if (rd_req_o) begin
        if ($urandom_range(99) < ready_pct) begin
          if (idx < 6) chk("R4 read address", rd_addr_o, exp_addr[idx]);
          else chk("R4 extra read", 1, 0);
          rd_ready_i = 1'b1;
          rd_data_i  = mem_word(rd_addr_o);
          idx++;
        end else begin
          rd_ready_i = 1'b0;
          rd_data_i  = $urandom;
        end
      end else begin
        rd_ready_i = 1'b0;
      end
      if (!seen) @(negedge clk);
    end
    if (!seen) chk("R9 completion seen", 0, 1);
    start_i = 1'b0; rd_ready_i = 1'b0;
    @(negedge clk);
    chk("R9 single-cycle strobe", {done_o, fault_o}, 2'b00);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start_i = 0; rd_ready_i = 0; rd_data_i = 0;
    ret_eip_i = 0; ret_cs_i = 0; ret_flags_i = 0; cur_esp_i = 0;
    ss_big_i = 0; ss_base_i = 0; ss_limit_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes low", {done_o, fault_o, rd_req_o}, 3'b000);
    chk("R1 regs zero", {new_eip_o, new_esp_o, new_flags_o}, 96'h0);
    chk("R1 selectors zero", seg_sel_o, 96'h0);
    chk("R1 attrs zero", seg_attr_o, 72'h0);

    // directed: exact limit fits (R2), 32-bit stack (R3)
    run_case(32'hDEAD_1234, 16'h1234, 32'h0002_0202, 32'h0001_0000,
             32'h0000_1000, 1'b1, 32'h0000_1000 - 32'd35, 0, 100);
    // one byte over -> fault (R2)
    run_case(32'h1, 16'h2, 32'h3, 32'h0, 32'h0000_1000, 1'b1,
             32'h0000_1000 - 32'd34, 0, 100);
    // R3 16-bit stack, junk upper bits, fits only if truncated
    run_case(32'hFFFF_8001, 16'hF000, 32'h0003_0046, 32'h0002_0000,
             32'h0000_FFFF, 1'b0, 32'hABCD_0100, 0, 60);
    // R3 same pointer in 32-bit mode exceeds limit -> fault
    run_case(32'h5, 16'h6, 32'h7, 32'h0, 32'h0000_FFFF, 1'b1,
             32'hABCD_0100, 0, 60);
    // R10 decoy start during a slow load
    run_case(32'h0BAD_C0DE, 16'h0777, 32'h0002_0000, 32'h0040_0000,
             32'hFFFF_FFFF, 1'b1, 32'h0000_2000, 1, 25);
    // R4 address wrap modulo 2^32
    run_case(32'h0000_FFFF, 16'hFFFF, 32'hFFFF_FFFF, 32'hFFFF_FFF0,
             32'hFFFF_FFFF, 1'b1, 32'h0000_0004, 0, 50);

    // constrained random
    for (int n = 0; n < 60; n++) begin
      logic [31:0] lim, esp;
      logic big;
      big = 1'($urandom_range(1));
      lim = (n % 3 == 0) ? 32'($urandom_range(20, 200)) : $urandom;
      esp = (n % 4 == 0) ? lim - 32'($urandom_range(30, 40)) : $urandom;
      run_case($urandom, 16'($urandom), $urandom, $urandom, lim, big, esp,
               bit'(n % 5 == 0), $urandom_range(20, 100));
    end
    finish_run();
  end

endmodule